// File: doc/BRIEF.md
# Maskable Event Interrupt Collector

This block gathers five event sources into sticky pending flags and drives one active-low interrupt request. Four sources arrive as one-cycle high pulses from neighbouring logic: two timer underflows, a clock alarm match and a serial shift-register full or empty event. The fifth is an external active-low pin. It passes through a synchroniser, and a falling edge on it registers as an event.

A single 8-bit register location serves both directions. A write changes the enable mask. Data bit 7 selects whether each 1 in bits 4..0 sets or clears the matching enable bit. A read returns the pending flags, with a summary bit on top that shows whether any pending flag is enabled. The same read clears the flags, so the request is released.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset, all pending flags and all enable bits are 0, the read word is 0x00 and `irq_n_o` is 1.
- R2: A one-cycle pulse on a source input sets its pending flag at the next clock edge. Flag positions are: bit 0 timer A, bit 1 timer B, bit 2 alarm, bit 3 serial, bit 4 external pin. A flag stays set until a read clears it.
- R3: `ext_flag_n_i` is resampled by two flops. A high-to-low transition sets flag bit 4 on the third rising clock edge after the pin falls. Holding the pin low, or a low-to-high transition, sets nothing.
- R4: A write with data bit 7 = 1 sets each enable bit whose data bit (4..0) is 1 and leaves the other enable bits unchanged.
- R5: A write with data bit 7 = 0 clears each enable bit whose data bit (4..0) is 1 and leaves the other enable bits unchanged.
- R6: The read word has bits 6 and 5 always 0. Bit 7 is 1 exactly when some pending flag has its enable bit set.
- R7: A read returns the current word and clears every pending flag at the clock edge that ends the read cycle. `irq_n_o` then returns to 1.
- R8: A source event in the same cycle as a read leaves its flag set after that read.
- R9: `irq_n_o` is 0 exactly while some pending flag is enabled. Pending flags that are not enabled leave it at 1.
- R10: A write changes only the enable mask, and the pending flags are unaffected. Without a write, the mask holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_a_evt_i | input | 1 | Timer A underflow pulse |
| tmr_b_evt_i | input | 1 | Timer B underflow pulse |
| alarm_evt_i | input | 1 | Clock alarm match pulse |
| serial_evt_i | input | 1 | Serial register full/empty pulse |
| ext_flag_n_i | input | 1 | Asynchronous external event pin, falling edge active |
| wr_en_i | input | 1 | Write strobe for the mask |
| wr_data_i | input | 8 | Write data: bit 7 set/clear select, bits 4..0 mask select |
| rd_en_i | input | 1 | Read strobe; clears flags at the edge |
| rd_data_o | output | 8 | Summary bit, zeros, pending flags |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
Each pulsed source is fired alone with every enable bit clear. This shows that its flag lands in the right bit and that the request stays quiet. The external pin is driven through a fall, a long low hold and a rise. That separates true edge detection from level sensing and confirms the three-edge latency. Mask writes set and clear overlapping bit patterns, including an empty select. This shows selective update against whole-mask overwrite. A read issued in the same cycle as a fresh event shows that clear-then-set ordering keeps the new event.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int SRC_N   = 5;
  localparam int DATA_W  = 8;
  localparam int SRC_TMA = 0;
  localparam int SRC_TMB = 1;
  localparam int SRC_ALM = 2;
  localparam int SRC_SER = 3;
  localparam int SRC_PIN = 4;
  localparam int CTL_BIT = DATA_W - 1;
  typedef logic [SRC_N-1:0] src_vec_t;
endpackage

// File: rtl/evt_irq_fall_det.sv
module evt_irq_fall_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic fall_o
);
  localparam int CHAIN_W = STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] chain_d;

  // Shift the pin in at position 0. The last position holds the previous synchronised value.
  always_comb begin
    chain_d = {chain_q[CHAIN_W-2:0], pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  assign fall_o = chain_q[CHAIN_W-1] & ~chain_q[CHAIN_W-2];

  // R3: edge detection gives a single-cycle pulse per transition
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/evt_irq_mask.sv
module evt_irq_mask
  import evt_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_i,
  input  logic     set_i,
  input  src_vec_t sel_i,
  output src_vec_t mask_o
);
  src_vec_t mask_q;
  src_vec_t mask_d;

  for (genvar i = 0; i < SRC_N; i++) begin : g_bit
    always_comb begin
      if (wr_i && sel_i[i]) mask_d[i] = set_i;
      else                  mask_d[i] = mask_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  assign mask_o = mask_q;

  assert_set_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && set_i) |=> ((mask_q & $past(sel_i)) == $past(sel_i)));
  assert_clr_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !set_i) |=> ((mask_q & $past(sel_i)) == '0));
  assert_hold_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(mask_q));
endmodule

// File: rtl/evt_irq_status.sv
module evt_irq_status
  import evt_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t evt_i,
  input  logic     clr_i,
  output src_vec_t status_o
);
  src_vec_t stat_q;
  src_vec_t stat_d;

  // A clear applies first, and events of the same cycle are ORed in after it.
  always_comb begin
    stat_d = (clr_i ? '0 : stat_q) | evt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign status_o = stat_q;

  assert_evt_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((stat_q & $past(evt_i)) == $past(evt_i)));
  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !(|evt_i)) |=> (stat_q == '0));
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_a_evt_i,
  input  logic              tmr_b_evt_i,
  input  logic              alarm_evt_i,
  input  logic              serial_evt_i,
  input  logic              ext_flag_n_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_n_o
);
  localparam int PAD_W = DATA_W - 1 - SRC_N;

  logic     pin_fall;
  src_vec_t evt_vec;
  src_vec_t status;
  src_vec_t mask;
  logic     pending;

  evt_irq_fall_det #(.STAGES(SYNC_STAGES)) u_fall (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (ext_flag_n_i),
    .fall_o (pin_fall)
  );

  always_comb begin
    evt_vec          = '0;
    evt_vec[SRC_TMA] = tmr_a_evt_i;
    evt_vec[SRC_TMB] = tmr_b_evt_i;
    evt_vec[SRC_ALM] = alarm_evt_i;
    evt_vec[SRC_SER] = serial_evt_i;
    evt_vec[SRC_PIN] = pin_fall;
  end

  evt_irq_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (evt_vec),
    .clr_i    (rd_en_i),
    .status_o (status)
  );

  evt_irq_mask u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (wr_en_i),
    .set_i  (wr_data_i[CTL_BIT]),
    .sel_i  (wr_data_i[SRC_N-1:0]),
    .mask_o (mask)
  );

  assign pending   = |(status & mask);
  assign rd_data_o = {pending, {PAD_W{1'b0}}, status};
  assign irq_n_o   = ~pending;

  // R10: a write with no same-cycle event or read leaves the flags unchanged
  assert_write_keeps_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !rd_en_i && !(|evt_vec)) |=> $stable(status));
  // R9: if no flag is pending, enabling mask bits cannot raise the request
  assert_no_flag_no_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0 && !(|evt_vec)) |=> irq_n_o);
endmodule

// File: tb/evt_irq_ctrl_tb_top.sv
module evt_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tma, tmb, alm, ser, pin_n;
  logic       wr_en, rd_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       irq_n;
  int         n_run = 0;
  int         n_fail = 0;

  always #5 clk = ~clk;

  evt_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .tmr_a_evt_i(tma), .tmr_b_evt_i(tmb), .alarm_evt_i(alm), .serial_evt_i(ser),
    .ext_flag_n_i(pin_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_data_o(rd_data), .irq_n_o(irq_n)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic pulse(input int src);
    case (src)
      0: tma = 1'b1;
      1: tmb = 1'b1;
      2: alm = 1'b1;
      default: ser = 1'b1;
    endcase
    step(1);
    {tma, tmb, alm, ser} = '0;
  endtask

  task automatic write(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    step(1);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic read_clear();
    rd_en = 1'b1;
    step(1);
    rd_en = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 read word", rd_data, 8'h00);
    check("R1 irq_n", {7'd0, irq_n}, 8'h01);
  endtask

  task automatic t_pulsed_sources();
    for (int s = 0; s < 4; s++) begin
      pulse(s);
      step(3);
      check("R2 sticky flag position", rd_data, 8'h01 << s);
      check("R9 masked flag keeps irq high", {7'd0, irq_n}, 8'h01);
      read_clear();
      check("R7 flags cleared by read", rd_data, 8'h00);
    end
  endtask

  task automatic t_pin_edges();
    pin_n = 1'b0;
    step(2);
    check("R3 no flag before third edge", rd_data, 8'h00);
    step(1);
    check("R3 falling edge sets bit 4", rd_data, 8'h10);
    read_clear();
    step(5);
    check("R3 held low does not re-set", rd_data, 8'h00);
    pin_n = 1'b1;
    step(4);
    check("R3 rising edge sets nothing", rd_data, 8'h00);
  endtask

  task automatic t_mask_ops();
    write(8'h83);
    pulse(1);
    check("R6 summary with enabled flag", rd_data, 8'h82);
    check("R9 irq asserted", {7'd0, irq_n}, 8'h00);
    write(8'h02);
    check("R5 clear drops summary, R10 flag kept", rd_data, 8'h02);
    check("R5 irq released", {7'd0, irq_n}, 8'h01);
    write(8'h82);
    check("R4 re-enable asserts irq", {7'd0, irq_n}, 8'h00);
    read_clear();
    check("R7 irq released after read", {7'd0, irq_n}, 8'h01);
    write(8'hFF);
    pulse(2);
    check("R4 set-all enables alarm; R6 bits 6:5 zero", rd_data, 8'h84);
    write(8'h00);
    check("R5 empty select changes nothing", rd_data, 8'h84);
    write(8'h1F);
    check("R5 clear-all", rd_data, 8'h04);
    check("R9 irq high when nothing enabled", {7'd0, irq_n}, 8'h01);
    read_clear();
  endtask

  task automatic t_read_collision();
    write(8'h9F);
    pulse(3);
    check("R6 serial pending and enabled", rd_data, 8'h88);
    rd_en = 1'b1; tma = 1'b1;
    step(1);
    rd_en = 1'b0; tma = 1'b0;
    check("R8 same-cycle event kept", rd_data, 8'h81);
    check("R8 irq still asserted", {7'd0, irq_n}, 8'h00);
    read_clear();
    check("R7 final clear", rd_data, 8'h00);
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    {tma, tmb, alm, ser} = '0;
    pin_n = 1'b1; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    step(3);
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_pulsed_sources();
    t_pin_edges();
    t_mask_ops();
    t_read_collision();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule